// File: doc/BRIEF.md
# Reflected CRC-32 Update Unit

This unit folds one data word into a running 32-bit CRC accumulator in bit-reflected form. It is the arithmetic step behind a CRC accumulate operation. A caller passes the current accumulator and a data operand of 8, 16 or 32 bits. The caller also picks one of two generator polynomials per operation: Castagnoli (0x1EDC6F41) or the Ethernet CRC-32 polynomial (0x04C11DB7). One clock later the unit returns the updated accumulator.

The unit applies no preset and no final inversion. Software that wants a standard message CRC seeds the accumulator with 0xFFFFFFFF, feeds the message through the unit, and inverts the last result. Size code 3 would request a 64-bit operand, which the unit does not accept. That code raises an illegal-size flag and forces the result to zero.

Top module: `crc32r_unit`

## Requirements
- R1: `size_code` selects the operand width: 0 means 8 bits, 1 means 16 bits and 2 means 32 bits. Operand bits above the selected width have no effect on the result.
- R2: When `poly_sel` is 1 the generator is 0x1EDC6F41. When `poly_sel` is 0 the generator is 0x04C11DB7.
- R3: The result equals the bit-serial reflected update with no preset and no final XOR. First the data is XORed into the low accumulator bits. Then, once per operand bit, the accumulator shifts right by one and is XORed with the reflected polynomial whenever the bit shifted out was 1.
- R4: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low at all other times.
- R5: `acc_out` holds its value in every cycle that follows a cycle without `in_valid`.
- R6: An operation with `size_code` 3 sets `bad_size` together with `out_valid` and drives `acc_out` to zero.
- R7: `bad_size` is low after every operation with a legal size code and while no result is presented.
- R8: While `rst` is high, and in the cycle after it falls, `out_valid`, `bad_size` and `acc_out` are all zero.
- R9: Chained updates compose. Seeding with 0xFFFFFFFF, feeding "123456789" byte by byte and inverting the last result gives 0xE3069283 with `poly_sel` 1 and 0xCBF43926 with `poly_sel` 0. One 32-bit update equals four 8-bit updates that take the data bytes least-significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| acc_in | input | 32 | Current CRC accumulator |
| data_in | input | 32 | Data operand; only the low selected width is used |
| size_code | input | 2 | Operand width code (0: 8, 1: 16, 2: 32, 3: illegal) |
| poly_sel | input | 1 | 1: Castagnoli polynomial, 0: CRC-32 polynomial |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| acc_out | output | 32 | Updated accumulator, held until the next operation |
| bad_size | output | 1 | Illegal size code flag, valid with `out_valid` |

## Verification
The timing assertions assume that `in_valid`, `size_code` and the operands are stable around the sampling edge. They also assume that requests may arrive in back-to-back cycles or with gaps. To stay within this, the bench changes every input only on the falling edge and holds each request for exactly one cycle. Value correctness comes from a bit-serial model in the bench. That model is applied to a table of operands that covers all widths, both polynomials, zero and all-ones accumulators, and operands with dirty upper bits.

// File: rtl/crc32r_pkg.sv
package crc32r_pkg;

  localparam int unsigned ACC_W = 32;

  typedef logic [ACC_W-1:0] acc_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_code_e;

  // Mirror a polynomial so the x^31 coefficient lands in bit 0.
  function automatic acc_t mirror(input acc_t v);
    acc_t r;
    for (int i = 0; i < ACC_W; i++) r[i] = v[ACC_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/crc32r_bitstage.sv
// One reflected division step: shift right, conditionally subtract the divisor.
module crc32r_bitstage #(
  parameter int unsigned ACC_W = 32
) (
  input  logic [ACC_W-1:0] cur,
  input  logic [ACC_W-1:0] poly_rev,
  output logic [ACC_W-1:0] nxt
);
  always_comb begin
    nxt = cur >> 1;
    if (cur[0]) nxt = nxt ^ poly_rev;
  end
endmodule

// File: rtl/crc32r_fold.sv
// Folds DATA_W operand bits into the accumulator through a chain of bit stages.
module crc32r_fold #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [DATA_W-1:0] data,
  input  logic [ACC_W-1:0]  poly_rev,
  output logic [ACC_W-1:0]  res
);
  localparam int unsigned STAGES = DATA_W;

  logic [ACC_W-1:0] chain [STAGES+1];

  assign chain[0] = acc ^ ACC_W'(data);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    crc32r_bitstage #(.ACC_W(ACC_W)) u_stage (
      .cur      (chain[s]),
      .poly_rev (poly_rev),
      .nxt      (chain[s+1])
    );
  end

  assign res = chain[STAGES];
endmodule

// File: rtl/crc32r_unit.sv
module crc32r_unit
  import crc32r_pkg::*;
#(
  parameter logic [31:0] POLY_CASTAGNOLI = 32'h1EDC6F41,
  parameter logic [31:0] POLY_ETHERNET   = 32'h04C11DB7,
  parameter int unsigned NUM_WIDTHS      = 3,
  parameter int unsigned BASE_W          = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] acc_in,
  input  logic [31:0] data_in,
  input  logic [1:0]  size_code,
  input  logic        poly_sel,
  output logic        out_valid,
  output logic [31:0] acc_out,
  output logic        bad_size
);
  localparam acc_t REV_CAST = mirror(POLY_CASTAGNOLI);
  localparam acc_t REV_ETH  = mirror(POLY_ETHERNET);

  acc_t poly_rev;
  acc_t width_res [NUM_WIDTHS];
  acc_t next_acc;
  logic next_bad;

  assign poly_rev = poly_sel ? REV_CAST : REV_ETH;

  for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
    localparam int unsigned DW = BASE_W << w;
    crc32r_fold #(.ACC_W(ACC_W), .DATA_W(DW)) u_fold (
      .acc      (acc_in),
      .data     (data_in[DW-1:0]),
      .poly_rev (poly_rev),
      .res      (width_res[w])
    );
  end

  always_comb begin
    next_bad = 1'b0;
    next_acc = '0;
    case (size_code_e'(size_code))
      SZ_BYTE: next_acc = width_res[0];
      SZ_HALF: next_acc = width_res[1];
      SZ_WORD: next_acc = width_res[2];
      default: next_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      bad_size  <= 1'b0;
      acc_out   <= '0;
    end else begin
      out_valid <= in_valid;
      bad_size  <= in_valid & next_bad;
      if (in_valid) acc_out <= next_acc;
    end
  end

  // R4: result strobe follows every request by one cycle
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R4: no strobe without a request
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R5: result held between operations
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc_out));
  // R6: illegal size flagged with zero result
  a_r6_bad_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'b11) |=> (bad_size && out_valid && acc_out == '0));
  // R7: legal sizes never flag
  a_r7_legal_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code != 2'b11) |=> !bad_size);
  // R7: flag only alongside a result
  a_r7_flag_with_valid: assert property (@(posedge clk) disable iff (rst)
    bad_size |-> out_valid);
  // R3: a zero accumulator with zero data stays zero
  a_r3_zero_maps_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_in == '0 && data_in == '0) |=> (acc_out == '0));
endmodule

// File: tb/crc32r_unit_tb.sv
module crc32r_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] acc_in, data_in;
  logic [1:0]  size_code;
  logic        poly_sel;
  logic        out_valid, bad_size;
  logic [31:0] acc_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crc32r_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
    .data_in(data_in), .size_code(size_code), .poly_sel(poly_sel),
    .out_valid(out_valid), .acc_out(acc_out), .bad_size(bad_size)
  );

  typedef struct packed {
    logic [31:0] acc;
    logic [31:0] data;
    logic [1:0]  sz;
    logic        sel;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0000, 32'h0000_0001, 2'd0, 1'b1},
    '{32'hFFFF_FFFF, 32'h0000_0031, 2'd0, 1'b1},
    '{32'hFFFF_FFFF, 32'h0000_0031, 2'd0, 1'b0},
    '{32'h1234_5678, 32'hABCD_BEEF, 2'd1, 1'b1},
    '{32'h8000_0000, 32'h0000_8000, 2'd1, 1'b0},
    '{32'hDEAD_BEEF, 32'h0102_0304, 2'd2, 1'b1},
    '{32'hDEAD_BEEF, 32'h0102_0304, 2'd2, 1'b0},
    '{32'h0000_0000, 32'hFFFF_FFFF, 2'd2, 1'b1},
    '{32'hFFFF_FFFF, 32'hFFFF_FF00, 2'd0, 1'b0},
    '{32'hA5A5_5A5A, 32'h7777_0000, 2'd1, 1'b1}
  };

  function automatic logic [31:0] model(input logic [31:0] acc, input logic [31:0] data,
                                        input logic [1:0] sz, input logic sel);
    logic [31:0] c;
    int n;
    c = acc;
    n = 8 << sz;
    for (int i = 0; i < n; i++) c[i] = c[i] ^ data[i];
    for (int i = 0; i < n; i++)
      c = (c >> 1) ^ (c[0] ? (sel ? 32'h82F6_3B78 : 32'hEDB8_8320) : 32'h0);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                        input logic sel, output logic [31:0] res,
                        output logic ov, output logic bs);
    @(negedge clk);
    acc_in = a; data_in = d; size_code = sz; poly_sel = sel; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    res = acc_out; ov = out_valid; bs = bad_size;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2, c;
    logic ov, bs;
    string msg;
    rst = 1'b1; in_valid = 1'b0; acc_in = '0; data_in = '0; size_code = '0; poly_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 valid", {31'b0, out_valid}, 32'd0);
    check("R8 flag", {31'b0, bad_size}, 32'd0);
    check("R8 acc", acc_out, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 after release", {30'b0, out_valid, bad_size}, 32'd0);

    // R1 R2 R3 R4 R7: table walk against bit-serial model
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].acc, VEC[i].data, VEC[i].sz, VEC[i].sel, r, ov, bs);
      check("R3 table", r, model(VEC[i].acc, VEC[i].data, VEC[i].sz, VEC[i].sel));
      check("R4 table valid", {31'b0, ov}, 32'd1);
      check("R7 table flag", {31'b0, bs}, 32'd0);
    end

    // R1: upper operand bits ignored
    run_op(32'h1357_9BDF, 32'h0000_00A5, 2'd0, 1'b1, r, ov, bs);
    run_op(32'h1357_9BDF, 32'hFFFF_FFA5, 2'd0, 1'b1, r2, ov, bs);
    check("R1 byte mask", r2, r);
    run_op(32'h1357_9BDF, 32'h0000_C3A5, 2'd1, 1'b0, r, ov, bs);
    run_op(32'h1357_9BDF, 32'h5A5A_C3A5, 2'd1, 1'b0, r2, ov, bs);
    check("R1 half mask", r2, r);

    // R2: polynomials give distinct results
    run_op(32'h0, 32'h0000_0080, 2'd0, 1'b1, r, ov, bs);
    check("R2 castagnoli", r, 32'h82F6_3B78);
    run_op(32'h0, 32'h0000_0080, 2'd0, 1'b0, r, ov, bs);
    check("R2 ethernet", r, 32'hEDB8_8320);

    // R5: hold across idle cycles
    run_op(32'hCAFE_F00D, 32'h1234_5678, 2'd2, 1'b1, r, ov, bs);
    repeat (4) @(negedge clk);
    check("R5 hold", acc_out, r);
    check("R4 idle valid", {31'b0, out_valid}, 32'd0);
    check("R7 idle flag", {31'b0, bad_size}, 32'd0);

    // R6: illegal size
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1'b1, r, ov, bs);
    check("R6 acc zero", r, 32'd0);
    check("R6 flag", {30'b0, ov, bs}, 32'd3);
    run_op(32'h0000_0001, 32'h0000_0000, 2'd2, 1'b0, r, ov, bs);
    check("R7 flag clears", {31'b0, bs}, 32'd0);

    // R9: check value of "123456789"
    for (int p = 0; p < 2; p++) begin
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < 9; k++) begin
        run_op(c, 32'h30 + 32'(k + 1), 2'd0, p[0], r, ov, bs);
        c = r;
      end
      msg = (p == 1) ? "R9 check castagnoli" : "R9 check ethernet";
      check(msg, ~c, (p == 1) ? 32'hE306_9283 : 32'hCBF4_3926);
    end

    // R9: word equals four LSB-first bytes
    run_op(32'h1234_5678, 32'hDEAD_BEEF, 2'd2, 1'b1, r2, ov, bs);
    c = 32'h1234_5678;
    for (int k = 0; k < 4; k++) begin
      run_op(c, {24'h0, 8'(32'hDEAD_BEEF >> (8 * k))}, 2'd0, 1'b1, r, ov, bs);
      c = r;
    end
    check("R9 word vs bytes", c, r2);

    // R4: back-to-back requests
    @(negedge clk);
    acc_in = 32'h0; data_in = 32'h80; size_code = 2'd0; poly_sel = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    poly_sel = 1'b1;
    check("R4 b2b first", acc_out, 32'hEDB8_8320);
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 b2b second", acc_out, 32'h82F6_3B78);
    check("R4 b2b valid", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    check("R4 b2b drop", {31'b0, out_valid}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule